// File: doc/BRIEF.md
# Indirect Register Front End with Status and Mailboxes

This block is the host-side register window in front of a bidirectional FIFO pair. It decodes one offset of a small address window. A write to that offset while idle loads a pointer. The single access that follows at the same offset reaches the internal register the pointer selects, and the window then falls back to pointer mode. A read while idle returns the status byte.

The internal registers are a command register, an interrupt mask, a byte-detect pattern, an outbound mailbox (host to board), a threshold register and an inbound mailbox (board to host). The status byte is built from the fill levels and flags that the external FIFO storage supplies. It also carries a sticky reset-occurred flag, which cannot be masked. A command can swap the status view to the peer port's status. Another command clears the FIFO logic, through a one-cycle pulse to the storage, and empties both mailboxes.

Top module: `fifo_ptr_regs`

## Requirements
- R1: After the asynchronous reset, the window expects a pointer write and rdata_o is 0. Both mailboxes, the mask, the byte-detect pattern, the thresholds and the swap mode are 0. The reset flag is set, so irq_o is 1.
- R2: A write at offset 2 while idle loads the pointer index from wdata_i[2:0]. The next read or write at offset 2 targets the indexed register, and the window then returns to idle. A read at offset 2 while idle returns the status byte on rdata_o in the following cycle.
- R3: Accesses at any offset other than 2 change no state, leave rdata_o unchanged and do not consume an armed pointer.
- R4: The index codes are 1 command, 2 mask, 3 byte-detect, 4 outbound mailbox, 5 threshold and 6 inbound mailbox. Index 0 and index 7 read as 0 and ignore writes. The mask keeps bits 6..0 and reads bit 7 as 0. A command read returns 0x40 in swap mode and 0 otherwise.
- R5: A command write of 0x80 produces a fifo_clr_o pulse one cycle long, starting in the next cycle. It also sets the reset flag, clears both mailboxes and the inbound-full flag, and leaves swap mode. Command values other than 0x80, 0x40 and 0x00 have no effect.
- R6: After command 0x40, a status read returns peer_status_i. Command 0x00 restores the block's own status.
- R7: The own status bits are:
  - bit 7: reset flag.
  - bit 6: out_level_i equals DEPTH.
  - bit 5: in_level_i equals 0.
  - bit 2: inbound mailbox full.
  - bit 1: in_level_i is nonzero and in_head_i equals the byte-detect pattern.
  - bit 0: frame_err_i.
- R8: Status bit 3 is set when in_level_i <= thr[3:0]*2^THR_SHIFT. Status bit 4 is set when out_level_i + thr[7:4]*2^THR_SHIFT >= DEPTH.
- R9: The reset flag is set by reset and by command 0x80. A status read clears it after returning it as 1.
- R10: irq_o equals the reset flag OR any own status bit 6..0 whose mask bit is set. This holds in swap mode too.
- R11: A host write to index 4 stores the byte, which appears on brd_out_data_o. A brd_out_rd_i pulse zeroes it, and a readback then returns 0. A host write in the same cycle as the pulse keeps the new byte.
- R12: A brd_in_wr_i pulse stores brd_in_data_i and sets the inbound-full flag. A host read of index 6 returns the byte and clears the flag. A board write in the same cycle as that read leaves the flag set. Host writes to index 6 change nothing.
- R13: When wr_i and rd_i are both high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Offset within the window |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered read data |
| out_level_i | input | LVL_W | Outbound FIFO fill level |
| in_level_i | input | LVL_W | Inbound FIFO fill level |
| in_head_i | input | 8 | Byte at the inbound FIFO head |
| frame_err_i | input | 1 | Parity or framing condition from storage |
| peer_status_i | input | 8 | Status byte of the other port |
| brd_in_wr_i | input | 1 | Board writes the inbound mailbox |
| brd_in_data_i | input | 8 | Board inbound mailbox data |
| brd_out_rd_i | input | 1 | Board consumes the outbound mailbox |
| brd_out_data_o | output | 8 | Outbound mailbox content |
| fifo_clr_o | output | 1 | One-cycle FIFO clear pulse |
| irq_o | output | 1 | Host interrupt request |

## Verification
A wrong pointer state shows up at the next access to offset 2. A stuck armed state returns a register value where status was expected. A lost index sends the following data write into the wrong register, and that error becomes visible at the next readback or on irq_o. Mailbox and flag errors appear within one cycle on brd_out_data_o and irq_o. The bench reference model compares rdata_o, irq_o, brd_out_data_o and fifo_clr_o on every clock, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [2:0] {
    IDX_NONE = 3'd0,
    IDX_CMD  = 3'd1,
    IDX_MASK = 3'd2,
    IDX_BDET = 3'd3,
    IDX_OMBX = 3'd4,
    IDX_THR  = 3'd5,
    IDX_IMBX = 3'd6,
    IDX_RSV  = 3'd7
  } idx_e;

  typedef struct packed {
    logic wr;
    logic rd;
    idx_e idx;
  } reg_acc_t;

  localparam logic [7:0] CMD_CLR  = 8'h80;
  localparam logic [7:0] CMD_SWAP = 8'h40;
  localparam logic [7:0] CMD_OWN  = 8'h00;
  localparam int unsigned N_MSK   = 7;
endpackage

// File: rtl/fpr_ptr_ctrl.sv
module fpr_ptr_ctrl import fpr_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_wr_i,
  input  logic       sel_rd_i,
  input  logic [2:0] ptr_i,
  output reg_acc_t   acc_o,
  output logic       stat_rd_o
);
  logic armed_q;
  idx_e idx_q;
  logic ptr_wr, idx_done;

  assign ptr_wr    = !armed_q && sel_wr_i;
  assign idx_done  = armed_q && (sel_wr_i || sel_rd_i);
  assign stat_rd_o = !armed_q && sel_rd_i && !sel_wr_i;
  assign acc_o.wr  = armed_q && sel_wr_i;
  assign acc_o.rd  = armed_q && sel_rd_i && !sel_wr_i;
  assign acc_o.idx = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      idx_q   <= IDX_NONE;
    end else if (ptr_wr) begin
      armed_q <= 1'b1;
      idx_q   <= idx_e'(ptr_i);
    end else if (idx_done) begin
      armed_q <= 1'b0;
      idx_q   <= IDX_NONE;
    end
  end

  // R2
  ptr_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr |=> armed_q);
  // R2
  ptr_oneshot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_done |=> !armed_q);
  // R3
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_wr_i && !sel_rd_i) |=> $stable(armed_q) && $stable(idx_q));
endmodule

// File: rtl/fpr_mbox.sv
module fpr_mbox (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       host_out_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       brd_out_rd_i,
  input  logic       brd_in_wr_i,
  input  logic [7:0] brd_in_data_i,
  input  logic       host_in_rd_i,
  output logic [7:0] out_mbox_o,
  output logic [7:0] in_mbox_o,
  output logic       in_full_o
);
  logic [7:0] out_q, in_q;
  logic       full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             out_q <= '0;
    else if (clr_i)          out_q <= '0;
    else if (host_out_wr_i)  out_q <= wdata_i;
    else if (brd_out_rd_i)   out_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      full_q <= 1'b0;
    end else if (clr_i) begin
      in_q   <= '0;
      full_q <= 1'b0;
    end else if (brd_in_wr_i) begin
      in_q   <= brd_in_data_i;
      full_q <= 1'b1;
    end else if (host_in_rd_i) begin
      full_q <= 1'b0;
    end
  end

  assign out_mbox_o = out_q;
  assign in_mbox_o  = in_q;
  assign in_full_o  = full_q;

  // R11
  ombx_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brd_out_rd_i && !host_out_wr_i && !clr_i) |=> (out_q == 8'h00));
  // R12
  imbx_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brd_in_wr_i && !clr_i) |=> full_q);
  // R5
  mbx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!full_q && out_q == 8'h00));
endmodule

// File: rtl/fpr_status.sv
module fpr_status import fpr_pkg::*; #(
  parameter  int unsigned DEPTH     = 512,
  parameter  int unsigned THR_SHIFT = 5,
  localparam int unsigned LVL_W     = $clog2(DEPTH + 1),
  localparam int unsigned SW        = LVL_W + THR_SHIFT + 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] out_level_i,
  input  logic [LVL_W-1:0] in_level_i,
  input  logic [7:0]       in_head_i,
  input  logic             frame_err_i,
  input  logic [7:0]       peer_status_i,
  input  logic [7:0]       bdet_i,
  input  logic [7:0]       thr_i,
  input  logic [N_MSK-1:0] mask_i,
  input  logic             in_full_i,
  input  logic             swap_i,
  input  logic             stat_rd_i,
  input  logic             set_flag_i,
  output logic [7:0]       stat_o,
  output logic             irq_o
);
  logic             flag_q;
  logic [N_MSK-1:0] own, hit;
  logic [SW-1:0]    af_sum, ae_lim;

  assign af_sum = SW'(out_level_i) + (SW'(thr_i[7:4]) << THR_SHIFT);
  assign ae_lim = SW'(thr_i[3:0]) << THR_SHIFT;

  assign own[6] = SW'(out_level_i) >= SW'(DEPTH);
  assign own[5] = in_level_i == '0;
  assign own[4] = af_sum >= SW'(DEPTH);
  assign own[3] = SW'(in_level_i) <= ae_lim;
  assign own[2] = in_full_i;
  assign own[1] = (in_level_i != '0) && (in_head_i == bdet_i);
  assign own[0] = frame_err_i;

  for (genvar b = 0; b < N_MSK; b++) begin : g_hit
    assign hit[b] = own[b] & mask_i[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b1;
    else if (set_flag_i) flag_q <= 1'b1;
    else if (stat_rd_i)  flag_q <= 1'b0;
  end

  assign stat_o = swap_i ? peer_status_i : {flag_q, own};
  assign irq_o  = flag_q | (|hit);

  // R9
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !set_flag_i) |=> !flag_q);
  // R9
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flag_i |=> flag_q);
  // R10
  flag_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> irq_o);
endmodule

// File: rtl/fifo_ptr_regs.sv
module fifo_ptr_regs import fpr_pkg::*; #(
  parameter  int unsigned ADDR_W    = 3,
  parameter  int unsigned PTR_OFS   = 2,
  parameter  int unsigned DEPTH     = 512,
  parameter  int unsigned THR_SHIFT = 5,
  localparam int unsigned LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [LVL_W-1:0]  out_level_i,
  input  logic [LVL_W-1:0]  in_level_i,
  input  logic [7:0]        in_head_i,
  input  logic              frame_err_i,
  input  logic [7:0]        peer_status_i,
  input  logic              brd_in_wr_i,
  input  logic [7:0]        brd_in_data_i,
  input  logic              brd_out_rd_i,
  output logic [7:0]        brd_out_data_o,
  output logic              fifo_clr_o
  ,output logic             irq_o
);
  logic             sel;
  reg_acc_t         acc;
  logic             stat_rd;
  logic             cmd_wr, clr;
  logic             swap_q;
  logic [N_MSK-1:0] mask_q;
  logic [7:0]       bdet_q, thr_q, stat;
  logic [7:0]       out_mbox, in_mbox;
  logic             in_full;
  logic [7:0]       idx_rd;
  logic             clr_q;

  assign sel    = addr_i == ADDR_W'(PTR_OFS);
  assign cmd_wr = acc.wr && acc.idx == IDX_CMD;
  assign clr    = cmd_wr && wdata_i == CMD_CLR;

  fpr_ptr_ctrl u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_wr_i  (sel && wr_i),
    .sel_rd_i  (sel && rd_i),
    .ptr_i     (wdata_i[2:0]),
    .acc_o     (acc),
    .stat_rd_o (stat_rd)
  );

  fpr_mbox u_mbox (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (clr),
    .host_out_wr_i (acc.wr && acc.idx == IDX_OMBX),
    .wdata_i       (wdata_i),
    .brd_out_rd_i  (brd_out_rd_i),
    .brd_in_wr_i   (brd_in_wr_i),
    .brd_in_data_i (brd_in_data_i),
    .host_in_rd_i  (acc.rd && acc.idx == IDX_IMBX),
    .out_mbox_o    (out_mbox),
    .in_mbox_o     (in_mbox),
    .in_full_o     (in_full)
  );

  fpr_status #(.DEPTH(DEPTH), .THR_SHIFT(THR_SHIFT)) u_stat (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .out_level_i   (out_level_i),
    .in_level_i    (in_level_i),
    .in_head_i     (in_head_i),
    .frame_err_i   (frame_err_i),
    .peer_status_i (peer_status_i),
    .bdet_i        (bdet_q),
    .thr_i         (thr_q),
    .mask_i        (mask_q),
    .in_full_i     (in_full),
    .swap_i        (swap_q),
    .stat_rd_i     (stat_rd),
    .set_flag_i    (clr),
    .stat_o        (stat),
    .irq_o         (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swap_q <= 1'b0;
      mask_q <= '0;
      bdet_q <= '0;
      thr_q  <= '0;
    end else if (acc.wr) begin
      unique case (acc.idx)
        IDX_CMD: begin
          if (wdata_i == CMD_CLR || wdata_i == CMD_OWN) swap_q <= 1'b0;
          else if (wdata_i == CMD_SWAP)                 swap_q <= 1'b1;
        end
        IDX_MASK: mask_q <= wdata_i[N_MSK-1:0];
        IDX_BDET: bdet_q <= wdata_i;
        IDX_THR:  thr_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (acc.idx)
      IDX_CMD:  idx_rd = {1'b0, swap_q, 6'b0};
      IDX_MASK: idx_rd = {1'b0, mask_q};
      IDX_BDET: idx_rd = bdet_q;
      IDX_OMBX: idx_rd = out_mbox;
      IDX_THR:  idx_rd = thr_q;
      IDX_IMBX: idx_rd = in_mbox;
      default:  idx_rd = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= clr;
      if (stat_rd)     rdata_o <= stat;
      else if (acc.rd) rdata_o <= idx_rd;
    end
  end

  assign fifo_clr_o     = clr_q;
  assign brd_out_data_o = out_mbox;

  // R5
  clr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_o |=> !fifo_clr_o);
  // R3
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> $stable(rdata_o));
  // R13
  wr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && wr_i && rd_i) |=> $stable(rdata_o));
endmodule

// File: tb/fifo_ptr_regs_tb.sv
module fifo_ptr_regs_tb;
  logic       clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, brd_out;
  logic [9:0] out_lvl = 0, in_lvl = 0;
  logic [7:0] in_head = 0, peer = 0, bi_data = 0;
  logic       ferr = 0, bi_wr = 0, bo_rd = 0;
  logic       fifo_clr, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_armed = 0, m_idx = 0, m_flag = 1, m_swap = 0, m_mask = 0, m_bd = 0;
  int m_thr = 0, m_omb = 0, m_imb = 0, m_ifull = 0, m_rdata = 0, m_clr = 0;

  always #5 clk = ~clk;

  fifo_ptr_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .out_level_i(out_lvl),
    .in_level_i(in_lvl), .in_head_i(in_head), .frame_err_i(ferr),
    .peer_status_i(peer), .brd_in_wr_i(bi_wr), .brd_in_data_i(bi_data),
    .brd_out_rd_i(bo_rd), .brd_out_data_o(brd_out), .fifo_clr_o(fifo_clr),
    .irq_o(irq)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  function automatic int own_st();
    int s = 0;
    if (out_lvl >= 512) s |= 64;
    if (in_lvl == 0) s |= 32;
    if (int'(out_lvl) + (m_thr / 16) * 32 >= 512) s |= 16;
    if (int'(in_lvl) <= (m_thr % 16) * 32) s |= 8;
    if (m_ifull != 0) s |= 4;
    if (in_lvl != 0 && int'(in_head) == m_bd) s |= 2;
    if (ferr) s |= 1;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_idx = 0; m_flag = 1; m_swap = 0; m_mask = 0; m_bd = 0;
      m_thr = 0; m_omb = 0; m_imb = 0; m_ifull = 0; m_rdata = 0; m_clr = 0;
    end else begin
      bit w, r, clr, howr, hird;
      int st;
      w = (addr == 2) && wr;
      r = (addr == 2) && rd && !wr;
      clr = 0; howr = 0; hird = 0;
      st = m_swap ? int'(peer) : ((m_flag << 7) | own_st());
      if (!m_armed) begin
        if (w) begin m_armed = 1; m_idx = wdata & 7; end
        else if (r) begin m_rdata = st; m_flag = 0; end
      end else if (w || r) begin
        if (w) begin
          case (m_idx)
            1: if (wdata == 8'h80) clr = 1;
               else if (wdata == 8'h40) m_swap = 1;
               else if (wdata == 8'h00) m_swap = 0;
            2: m_mask = wdata & 8'h7f;
            3: m_bd = wdata;
            4: howr = 1;
            5: m_thr = wdata;
            default: ;
          endcase
        end else begin
          case (m_idx)
            1: m_rdata = m_swap ? 8'h40 : 0;
            2: m_rdata = m_mask;
            3: m_rdata = m_bd;
            4: m_rdata = m_omb;
            5: m_rdata = m_thr;
            6: begin m_rdata = m_imb; hird = 1; end
            default: m_rdata = 0;
          endcase
        end
        m_armed = 0; m_idx = 0;
      end
      if (clr) begin m_flag = 1; m_swap = 0; end
      if (clr) m_omb = 0;
      else if (howr) m_omb = wdata;
      else if (bo_rd) m_omb = 0;
      if (clr) begin m_imb = 0; m_ifull = 0; end
      else if (bi_wr) begin m_imb = bi_data; m_ifull = 1; end
      else if (hird) m_ifull = 0;
      m_clr = clr;
    end
    #1;
    if (rst_n && !done) begin
      chk("rdata", rdata, m_rdata);
      chk("brd_out", brd_out, m_omb);
      chk("fifo_clr", fifo_clr, m_clr);
      chk("irq", irq, (m_flag != 0 || (own_st() & m_mask) != 0) ? 1 : 0);
    end
  end

  task automatic bus(int a, bit w, bit r, int d);
    @(negedge clk); addr = a; wr = w; rd = r; wdata = d;
    @(negedge clk); wr = 0; rd = 0;
  endtask
  task automatic wreg(int idx, int v); bus(2, 1, 0, idx); bus(2, 1, 0, v); endtask
  task automatic rreg(int idx); bus(2, 1, 0, idx); bus(2, 0, 1, 0); endtask
  task automatic rstat(); bus(2, 0, 1, 0); endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    cur_req = "R1";
    chk("reset rdata", rdata, 0);
    chk("reset irq", irq, 1);
    chk("reset brd_out", brd_out, 0);
    chk("reset fifo_clr", fifo_clr, 0);

    cur_req = "R9";
    rstat(); rstat();
    cur_req = "R2";
    wreg(2, 8'hff); rreg(2); rstat();
    cur_req = "R4";
    wreg(3, 8'h5a); rreg(3); wreg(5, 8'h21); rreg(5);
    rreg(0); wreg(7, 8'h11); rreg(7); rreg(1);
    bus(2, 1, 0, 8'hfa); bus(2, 0, 1, 0);
    cur_req = "R3";
    bus(2, 1, 0, 2); bus(0, 1, 0, 8'h01); bus(0, 0, 1, 0); bus(5, 1, 0, 3);
    bus(2, 0, 1, 0);
    cur_req = "R7";
    out_lvl = 512; in_lvl = 0; rstat();
    in_lvl = 7; in_head = 8'h5a; ferr = 1; rstat();
    in_head = 8'h00; ferr = 0; out_lvl = 3; rstat();
    cur_req = "R8";
    wreg(5, 8'h32);
    in_lvl = 64; out_lvl = 416; rstat();
    in_lvl = 65; out_lvl = 415; rstat();
    in_lvl = 0; rstat();
    cur_req = "R10";
    wreg(2, 8'h01); ferr = 1; @(negedge clk); ferr = 0; @(negedge clk);
    wreg(2, 8'h20); in_lvl = 5; @(negedge clk); in_lvl = 0; wreg(2, 0);
    cur_req = "R11";
    wreg(4, 8'h33); rreg(4);
    @(negedge clk); bo_rd = 1; @(negedge clk); bo_rd = 0;
    rreg(4);
    bus(2, 1, 0, 4);
    @(negedge clk); wr = 1; wdata = 8'h44; bo_rd = 1;
    @(negedge clk); wr = 0; bo_rd = 0;
    rreg(4);
    cur_req = "R12";
    wreg(2, 8'h04);
    @(negedge clk); bi_wr = 1; bi_data = 8'h77; @(negedge clk); bi_wr = 0;
    rstat(); rreg(6); rstat();
    wreg(6, 8'h99); rreg(6);
    bus(2, 1, 0, 6);
    @(negedge clk); rd = 1; bi_wr = 1; bi_data = 8'h12;
    @(negedge clk); rd = 0; bi_wr = 0;
    rstat();
    cur_req = "R6";
    peer = 8'hc3; wreg(1, 8'h40); rstat(); rreg(1); wreg(1, 8'h00); rstat(); rreg(1);
    cur_req = "R5";
    wreg(4, 8'h55); wreg(1, 8'h40); wreg(1, 8'h12); rreg(1);
    @(negedge clk); bi_wr = 1; bi_data = 8'h66; @(negedge clk); bi_wr = 0;
    wreg(1, 8'h80); rstat(); rreg(4); rreg(6); rreg(1); rstat();
    cur_req = "R13";
    @(negedge clk); addr = 2; wr = 1; rd = 1; wdata = 3;
    @(negedge clk); wr = 0; rd = 0;
    bus(2, 0, 1, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule